// File: doc/BRIEF.md
# Cartridge Bank Switching Mapper

This block sits between a CPU, a video controller and a pair of large ROMs. It turns short addresses into long ones. The CPU sees four 8 KB program windows above 0x8000. The first two windows each follow a writable bank register. The top two windows are pinned to the last two pages of program ROM. The video side sees eight 1 KB pattern windows, each mapped to a character ROM page by a writable register. The mapper also drives a single bit that picks between two nametable mirroring arrangements.

Software programs the banks by writing to a fixed set of addresses. Each bank number is folded into the ROM size given by the parameters, so a number that is too large wraps around. Mirroring follows bit 6 of writes to the first program bank register until a write to the dedicated mirroring address is seen. From then on, only the dedicated register controls mirroring. Both address translations are combinational from the register contents.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, program window 0 maps page 0, window 1 maps page 1 mod PRG_PAGES, character window i (i = 0..7) maps page i mod CHR_PAGES, mirror_sel is 0 and the mirroring lock is clear.
- R2: A write of D to 0x8000 maps window 0 (cpu_addr 0x8000–0x9FFF) to page D mod PRG_PAGES. prg_rom_addr = page·8192 + cpu_addr[12:0], and the window is selected by cpu_addr[14:13] (00, 01, 10, 11 for windows 0 to 3).
- R3: A write of D to 0x8001 maps window 1 (0xA000–0xBFFF) to page D mod PRG_PAGES.
- R4: Window 2 (0xC000–0xDFFF) always maps page PRG_PAGES−2 and window 3 (0xE000–0xFFFF) always maps page PRG_PAGES−1.
- R5: A write of D to 0x8002 maps character windows 0 and 1 to pages (2D) mod CHR_PAGES and (2D+1) mod CHR_PAGES. A write to 0x8003 does the same for windows 2 and 3. chr_rom_addr = page·1024 + ppu_addr[9:0], and the window is selected by ppu_addr[12:10].
- R6: A write of D to 0xA000, 0xA001, 0xA002 or 0xA003 maps character window 4, 5, 6 or 7 to page (2D) mod CHR_PAGES.
- R7: While the lock is clear, a write to 0x8000 sets mirror_sel to bit 6 of the data.
- R8: A write to 0xE000 sets mirror_sel to bit 6 of the data and sets the lock. The lock stays set. Later writes to 0x8000 leave mirror_sel unchanged. Later writes to 0xE000 still update it.
- R9: A write to any other address, and any cycle with cpu_wr low, changes no mapping and no mirror_sel.
- R10: prg_rom_addr and chr_rom_addr follow changes of cpu_addr and ppu_addr with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising clock edge |
| cpu_addr | input | 16 | CPU address, used for write decode and program translation |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video pattern address |
| prg_rom_addr | output | PRG_W+13 | Extended program ROM address |
| chr_rom_addr | output | CHR_W+10 | Extended character ROM address |
| mirror_sel | output | 1 | Nametable mirroring select |

## Verification
Every bank register is visible at the ports. Sweeping the address of each window through the translation shows the register's contents in the same cycle. A register that is corrupted, or written by a decode that hits the wrong address, therefore shows a wrong page on the next lookup of its window. The mirroring lock is hidden, but a wrong lock value shows in mirror_sel on the next write to 0x8000 whose bit 6 differs from the current mirror_sel. The bench uses non-power-of-two ROM sizes, so a missing or wrong modulo fold shows on the first bank number past the size.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

   localparam logic [15:0] ADDR_PRG0  = 16'h8000;
   localparam logic [15:0] ADDR_PRG1  = 16'h8001;
   localparam logic [15:0] ADDR_CHR01 = 16'h8002;
   localparam logic [15:0] ADDR_CHR23 = 16'h8003;
   localparam logic [15:0] ADDR_CHR4  = 16'hA000;
   localparam logic [15:0] ADDR_MIRR  = 16'hE000;

   localparam int NUM_PRG_WIN = 4;
   localparam int NUM_CHR_WIN = 8;
   localparam int NUM_CHR_HI  = 4;

   // one strobe per writable target, at most one set per cycle
   typedef struct packed {
      logic                  prg0;
      logic                  prg1;
      logic                  chr01;
      logic                  chr23;
      logic [NUM_CHR_HI-1:0] chr_hi;
      logic                  mirr;
   } wr_hit_t;

endpackage

// File: rtl/cart_map_decode.sv
module cart_map_decode
   import cart_map_pkg::*;
(
   input  logic        wr_en,
   input  logic [15:0] addr,
   output wr_hit_t     hit
);

   always_comb begin
      hit = '0;
      if (wr_en) begin
         hit.prg0  = (addr == ADDR_PRG0);
         hit.prg1  = (addr == ADDR_PRG1);
         hit.chr01 = (addr == ADDR_CHR01);
         hit.chr23 = (addr == ADDR_CHR23);
         hit.mirr  = (addr == ADDR_MIRR);
         for (int k = 0; k < NUM_CHR_HI; k++) begin
            hit.chr_hi[k] = (addr == (ADDR_CHR4 + 16'(k)));
         end
      end
   end

   // R9: exact match decode never selects two targets
   always_comb begin
      assert_single_hit_R9: assert ($onehot0(hit));
   end

endmodule

// File: rtl/cart_map_page_wrap.sv
module cart_map_page_wrap #(
   parameter int PAGES = 16,
   localparam int W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
   input  logic [8:0]   raw,
   output logic [W-1:0] page
);

   localparam bit IS_POW2 = ((PAGES & (PAGES - 1)) == 0);

   generate
      if (IS_POW2) begin : g_mask
         assign page = W'(raw & 9'(PAGES - 1));
      end else begin : g_mod
         assign page = W'(raw % 9'(PAGES));
      end
   endgenerate

endmodule

// File: rtl/cart_map_bank_regs.sv
module cart_map_bank_regs
   import cart_map_pkg::*;
#(
   parameter int PRG_PAGES = 16,
   parameter int CHR_PAGES = 128,
   localparam int PRG_W = $clog2(PRG_PAGES),
   localparam int CHR_W = (CHR_PAGES > 1) ? $clog2(CHR_PAGES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  wr_hit_t                           hit,
   input  logic [7:0]                        wdata,
   output logic [1:0][PRG_W-1:0]             prg_bank,
   output logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank,
   output logic                              mirror_sel
);

   localparam logic [PRG_W-1:0] PRG_RST1 = PRG_W'(1 % PRG_PAGES);

   logic [PRG_W-1:0] prg_wrapped;
   logic [CHR_W-1:0] chr_even;
   logic [CHR_W-1:0] chr_odd;
   logic             lock_q;

   cart_map_page_wrap #(.PAGES(PRG_PAGES)) u_wrap_prg (
      .raw  ({1'b0, wdata}),
      .page (prg_wrapped)
   );

   cart_map_page_wrap #(.PAGES(CHR_PAGES)) u_wrap_even (
      .raw  ({wdata, 1'b0}),
      .page (chr_even)
   );

   cart_map_page_wrap #(.PAGES(CHR_PAGES)) u_wrap_odd (
      .raw  ({wdata, 1'b1}),
      .page (chr_odd)
   );

   // program banks for the two switchable windows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_bank[0] <= '0;
         prg_bank[1] <= PRG_RST1;
      end else begin
         if (hit.prg0) prg_bank[0] <= prg_wrapped;
         if (hit.prg1) prg_bank[1] <= prg_wrapped;
      end
   end

   // character banks: windows 0..3 are loaded in pairs, 4..7 one each
   generate
      for (genvar i = 0; i < NUM_CHR_WIN; i++) begin : g_chr
         localparam logic [CHR_W-1:0] RST_PAGE = CHR_W'(i % CHR_PAGES);
         logic             load;
         logic [CHR_W-1:0] next;
         if (i < 2) begin : g_pair_lo
            assign load = hit.chr01;
            assign next = (i % 2 == 1) ? chr_odd : chr_even;
         end else if (i < 4) begin : g_pair_hi
            assign load = hit.chr23;
            assign next = (i % 2 == 1) ? chr_odd : chr_even;
         end else begin : g_single
            assign load = hit.chr_hi[i-4];
            assign next = chr_even;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    chr_bank[i] <= RST_PAGE;
            else if (load) chr_bank[i] <= next;
         end
      end
   endgenerate

   // mirroring: follows the first program bank write until locked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mirror_sel <= 1'b0;
         lock_q     <= 1'b0;
      end else if (hit.mirr) begin
         mirror_sel <= wdata[6];
         lock_q     <= 1'b1;
      end else if (hit.prg0 && !lock_q) begin
         mirror_sel <= wdata[6];
      end
   end

   assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !hit.mirr) |=> $stable(mirror_sel));

   assert_early_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit.prg0 && !lock_q) |=> (mirror_sel == $past(wdata[6])));

   assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> ($stable(prg_bank) && $stable(chr_bank) && $stable(mirror_sel)));

   assert_prg_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit.prg0 |=> ({1'b0, prg_bank[0]} < (PRG_W+1)'(PRG_PAGES)));

endmodule

// File: rtl/cart_map_prg_xlate.sv
module cart_map_prg_xlate #(
   parameter int PRG_PAGES = 16,
   localparam int PRG_W = $clog2(PRG_PAGES)
) (
   input  logic [1:0][PRG_W-1:0] prg_bank,
   input  logic [14:0]           cpu_addr,
   output logic [PRG_W+12:0]     prg_rom_addr
);

   localparam logic [PRG_W-1:0] PAGE_LAST = PRG_W'(PRG_PAGES - 1);
   localparam logic [PRG_W-1:0] PAGE_PREV = PRG_W'(PRG_PAGES - 2);

   logic [PRG_W-1:0] page;

   always_comb begin
      unique case (cpu_addr[14:13])
         2'b00:   page = prg_bank[0];
         2'b01:   page = prg_bank[1];
         2'b10:   page = PAGE_PREV;
         default: page = PAGE_LAST;
      endcase
   end

   assign prg_rom_addr = {page, cpu_addr[12:0]};

   // R4: the top window reaches the last program page
   always_comb begin
      if (cpu_addr[14:13] == 2'b11) begin
         assert_fixed_top_R4: assert (prg_rom_addr[PRG_W+12:13] == PAGE_LAST);
      end
   end

endmodule

// File: rtl/cart_map_chr_xlate.sv
module cart_map_chr_xlate
   import cart_map_pkg::*;
#(
   parameter int CHR_PAGES = 128,
   localparam int CHR_W = (CHR_PAGES > 1) ? $clog2(CHR_PAGES) : 1
) (
   input  logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank,
   input  logic [12:0]                       ppu_addr,
   output logic [CHR_W+9:0]                  chr_rom_addr
);

   logic [CHR_W-1:0] page;

   assign page         = chr_bank[ppu_addr[12:10]];
   assign chr_rom_addr = {page, ppu_addr[9:0]};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cart_map_pkg::*;
#(
   parameter int PRG_PAGES = 16,
   parameter int CHR_PAGES = 128,
   localparam int PRG_W = $clog2(PRG_PAGES),
   localparam int CHR_W = (CHR_PAGES > 1) ? $clog2(CHR_PAGES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_wr,
   input  logic [15:0]          cpu_addr,
   input  logic [7:0]           cpu_data,
   input  logic [12:0]          ppu_addr,
   output logic [PRG_W+12:0]    prg_rom_addr,
   output logic [CHR_W+9:0]     chr_rom_addr,
   output logic                 mirror_sel
);

   generate
      if (PRG_PAGES < 2 || PRG_PAGES > 256) begin : g_bad_prg
         $error("PRG_PAGES must lie in 2..256");
      end
      if (CHR_PAGES < 1 || CHR_PAGES > 512) begin : g_bad_chr
         $error("CHR_PAGES must lie in 1..512");
      end
   endgenerate

   wr_hit_t                           hit;
   logic [1:0][PRG_W-1:0]             prg_bank;
   logic [NUM_CHR_WIN-1:0][CHR_W-1:0] chr_bank;

   cart_map_decode u_decode (
      .wr_en (cpu_wr),
      .addr  (cpu_addr),
      .hit   (hit)
   );

   cart_map_bank_regs #(
      .PRG_PAGES (PRG_PAGES),
      .CHR_PAGES (CHR_PAGES)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .wdata      (cpu_data),
      .prg_bank   (prg_bank),
      .chr_bank   (chr_bank),
      .mirror_sel (mirror_sel)
   );

   cart_map_prg_xlate #(.PRG_PAGES(PRG_PAGES)) u_prg (
      .prg_bank     (prg_bank),
      .cpu_addr     (cpu_addr[14:0]),
      .prg_rom_addr (prg_rom_addr)
   );

   cart_map_chr_xlate #(.CHR_PAGES(CHR_PAGES)) u_chr (
      .chr_bank     (chr_bank),
      .ppu_addr     (ppu_addr),
      .chr_rom_addr (chr_rom_addr)
   );

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

   localparam int P  = 12;
   localparam int C  = 40;
   localparam int PW = $clog2(P);
   localparam int CW = $clog2(C);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [15:0]   cpu_addr = 16'h0000;
   logic [7:0]    cpu_data = 8'h00;
   logic [12:0]   ppu_addr = 13'h0000;
   logic [PW+12:0] prg_rom_addr;
   logic [CW+9:0]  chr_rom_addr;
   logic          mirror_sel;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   int exp_prg [2];
   int exp_chr [8];
   bit exp_mir;
   bit exp_lock;

   cart_bank_mapper #(.PRG_PAGES(P), .CHR_PAGES(C)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_wr       (cpu_wr),
      .cpu_addr     (cpu_addr),
      .cpu_data     (cpu_data),
      .ppu_addr     (ppu_addr),
      .prg_rom_addr (prg_rom_addr),
      .chr_rom_addr (chr_rom_addr),
      .mirror_sel   (mirror_sel)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus write plus update of the bench's own model of the mapping
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit en = 1'b1);
      @(negedge clk);
      cpu_addr = a;
      cpu_data = d;
      cpu_wr   = en;
      @(negedge clk);
      cpu_wr   = 1'b0;
      if (en) begin
         case (a)
            16'h8000: begin
               exp_prg[0] = d % P;
               if (!exp_lock) exp_mir = d[6];
            end
            16'h8001: exp_prg[1] = d % P;
            16'h8002: begin exp_chr[0] = (2*d) % C; exp_chr[1] = (2*d+1) % C; end
            16'h8003: begin exp_chr[2] = (2*d) % C; exp_chr[3] = (2*d+1) % C; end
            16'hA000: exp_chr[4] = (2*d) % C;
            16'hA001: exp_chr[5] = (2*d) % C;
            16'hA002: exp_chr[6] = (2*d) % C;
            16'hA003: exp_chr[7] = (2*d) % C;
            16'hE000: begin exp_mir = d[6]; exp_lock = 1'b1; end
            default: ;
         endcase
      end
   endtask

   task automatic check_all(input string tag, input int seed);
      for (int w = 0; w < 4; w++) begin
         int off;
         int pg;
         off = (seed * 37 + w * 1111) % 8192;
         pg  = (w == 0) ? exp_prg[0] : (w == 1) ? exp_prg[1] : (w == 2) ? P - 2 : P - 1;
         cpu_addr = 16'(32'h8000 + w * 8192 + off);
         #1;
         check($sformatf("%s prg window %0d", tag, w), int'(prg_rom_addr), pg * 8192 + off);
      end
      for (int w = 0; w < 8; w++) begin
         int off;
         off = (seed * 13 + w * 101) % 1024;
         ppu_addr = 13'(w * 1024 + off);
         #1;
         check($sformatf("%s chr window %0d", tag, w), int'(chr_rom_addr), exp_chr[w] * 1024 + off);
      end
      check($sformatf("%s mirror", tag), int'(mirror_sel), int'(exp_mir));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      exp_prg[0] = 0;
      exp_prg[1] = 1 % P;
      for (int i = 0; i < 8; i++) exp_chr[i] = i % C;
      exp_mir  = 1'b0;
      exp_lock = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset", 0);

      // R2 and R3: full data sweep of both switchable windows, also checks R4
      for (int d = 0; d < 256; d++) begin
         wr(16'h8000, 8'(d));
         check_all("R2 R4 prg0 sweep", d);
      end
      for (int d = 0; d < 256; d++) begin
         wr(16'h8001, 8'(d));
         check_all("R3 prg1 sweep", d);
      end

      // R5: paired character windows
      for (int d = 0; d < 256; d++) begin
         wr(16'h8002, 8'(d));
         check_all("R5 chr01 sweep", d);
         wr(16'h8003, 8'(255 - d));
         check_all("R5 chr23 sweep", d + 7);
      end

      // R6: single character windows
      for (int d = 0; d < 256; d++) begin
         for (int k = 0; k < 4; k++) begin
            wr(16'(32'hA000 + k), 8'((d + 61 * k) % 256));
         end
         check_all("R6 chr hi sweep", d);
      end

      // R7: mirroring follows the first program bank before the lock
      wr(16'h8000, 8'h40);
      check("R7 mirror from prg0 bit6=1", int'(mirror_sel), 1);
      wr(16'h8000, 8'hBF);
      check("R7 mirror from prg0 bit6=0", int'(mirror_sel), 0);
      wr(16'h8000, 8'h45);
      check_all("R7 state", 3);

      // R8: dedicated register takes over for good
      wr(16'hE000, 8'h00);
      check("R8 mirror from dedicated bit6=0", int'(mirror_sel), 0);
      wr(16'h8000, 8'h40);
      check("R8 locked prg0 write", int'(mirror_sel), 0);
      check_all("R8 locked bank still moves", 4);
      wr(16'hE000, 8'h40);
      check("R8 dedicated still updates", int'(mirror_sel), 1);
      wr(16'h8000, 8'h00);
      check("R8 locked prg0 write again", int'(mirror_sel), 1);
      wr(16'hE000, 8'hBF);
      check("R8 dedicated to 0", int'(mirror_sel), 0);

      // R9: near misses and writes with the strobe low change nothing
      wr(16'h8004, 8'hFF); check_all("R9 addr 8004", 10);
      wr(16'h8007, 8'hFF); check_all("R9 addr 8007", 11);
      wr(16'hA004, 8'hFF); check_all("R9 addr A004", 12);
      wr(16'hC000, 8'hFF); check_all("R9 addr C000", 13);
      wr(16'hC001, 8'hFF); check_all("R9 addr C001", 14);
      wr(16'hE001, 8'hFF); check_all("R9 addr E001", 15);
      wr(16'h9000, 8'hFF); check_all("R9 addr 9000", 16);
      wr(16'h0000, 8'hFF); check_all("R9 addr 0000", 17);
      wr(16'h0002, 8'hFF); check_all("R9 addr 0002", 18);
      wr(16'h8000, 8'h07, 1'b0); check_all("R9 strobe low 8000", 19);
      wr(16'h8002, 8'h07, 1'b0); check_all("R9 strobe low 8002", 20);
      wr(16'hE000, 8'h40, 1'b0); check_all("R9 strobe low E000", 21);

      // R10: lookups change between clock edges
      @(posedge clk);
      #3;
      cpu_addr = 16'hE123;
      ppu_addr = 13'h1C55;
      #1;
      check("R10 prg comb", int'(prg_rom_addr), (P - 1) * 8192 + 16'h0123);
      check("R10 chr comb", int'(chr_rom_addr), exp_chr[7] * 1024 + 13'h0055);
      cpu_addr = 16'hC001;
      ppu_addr = 13'h0401;
      #1;
      check("R10 prg comb 2", int'(prg_rom_addr), (P - 2) * 8192 + 1);
      check("R10 chr comb 2", int'(chr_rom_addr), exp_chr[1] * 1024 + 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule